// File: doc/BRIEF.md
# Frequency Synthesizer Configuration Loader

This block holds the settings of a clock synthesizer: a 6-bit feedback divider value, two 3-bit output divider codes (channel A and channel B) and a 2-bit test selector. Settings arrive by one of two routes. The first is a set of parallel pins with an active-low load strobe: while that strobe is low, the pins pass straight to the setting registers, and its rising edge freezes them. The second is a three-wire serial port made of a serial clock, a data line and a serial load strobe. The parallel strobe takes priority. When it is low, the block is in parallel mode whatever the serial strobe does.

All strobe, serial and parallel inputs are sampled on a fast system clock through two-flop synchronizers. Edges are detected on the synchronized copies. Each serial clock phase must last at least four system clocks. A test output pin is driven by a multiplexer controlled by the test selector, and a registered flag reports whether the feedback divider value lies in the range where the loop can lock.

The control is a three-state machine:
- `S_PAR`: parallel tracking.
- `S_SER_IDLE`: serial shifting with the settings held.
- `S_SER_PASS`: serial load strobe high, so shifted contents pass through to the settings.

Transitions:
- From any state to `S_PAR` when the parallel strobe is low.
- `S_PAR` to `S_SER_IDLE` on a parallel strobe rise while the serial strobe is low.
- `S_PAR` to `S_SER_PASS` on a parallel strobe rise while the serial strobe is high.
- `S_SER_IDLE` to `S_SER_PASS` when the serial strobe goes high. This transition copies the shift register into the settings.
- `S_SER_PASS` to `S_SER_IDLE` when the serial strobe goes low. This transition freezes the settings.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `par_ld_n_i` is low, `m_o`, `na_o` and `nb_o` follow `par_m_i`, `par_na_i` and `par_nb_i` within three system clocks.
- R2: A rising edge of `par_ld_n_i` captures the parallel values. Later changes on the parallel pins have no effect while `par_ld_n_i` stays high.
- R3: With `par_ld_n_i` high, each rising edge of `ser_clk_i` shifts `ser_dat_i` in. A 14-bit frame is sent in this order: T1 first, then T0, NB[2:0], NA[2:0] and M[5:0] (MSB first). After loading, `{tsel_o, nb_o, na_o, m_o}` equals the frame, with the first bit at the top.
- R4: A rising edge of `ser_ld_i` while `par_ld_n_i` is high copies the shift register into the M, NA, NB and test-select registers. Shifting alone, before that strobe, leaves the outputs unchanged.
- R5: While `ser_ld_i` stays high, each rising edge of `ser_clk_i` updates the outputs to the new shift register contents.
- R6: After `ser_ld_i` falls, the outputs hold, and further serial clocks do not change them.
- R7: Outside parallel mode, `test_o` is selected by `tsel_o`:
  - 00: constant 0.
  - 01: the oldest bit of the shift register (the bit shifted in 14 serial clocks earlier).
  - 10: `fb_div_i`.
  - 11: `outa_clk_i`.
- R8: `test_o` is 0 while the block is in parallel mode.
- R9: `m_in_range_o` is 1 exactly when `m_o` is between 25 and 31 inclusive, and it changes in the same cycle as `m_o`.
- R10: During reset, all setting outputs, `test_o` and `m_in_range_o` are 0, and the block starts in parallel mode.
- R11: While `par_ld_n_i` is low, the serial strobe and serial clock have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial port clock |
| ser_dat_i | input | 1 | Serial port data |
| ser_ld_i | input | 1 | Serial load strobe |
| par_ld_n_i | input | 1 | Parallel load strobe, low = transparent |
| par_m_i | input | 6 | Parallel feedback divider value |
| par_na_i | input | 3 | Parallel output A divider code |
| par_nb_i | input | 3 | Parallel output B divider code |
| fb_div_i | input | 1 | Feedback divider output, fed to the test mux |
| outa_clk_i | input | 1 | Output A clock, fed to the test mux |
| m_o | output | 6 | Feedback divider value |
| na_o | output | 3 | Output A divider code |
| nb_o | output | 3 | Output B divider code |
| tsel_o | output | 2 | Test selector |
| test_o | output | 1 | Test pin |
| m_in_range_o | output | 1 | M value inside the lock range |

## Verification
A wrong state shows up at the ports in a few cycles. If the machine falls out of parallel tracking, pin changes stop reaching `m_o` within three clocks. If it stays in pass-through after the serial strobe falls, a single extra serial clock alters the settings. A wrong bit order in the shift register shows up as misplaced fields right after the first loaded frame. A wrong oldest-bit tap shows up in test-select 01 after one extra serial clock.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    parameter int unsigned CFG_M_W = 6;
    parameter int unsigned CFG_N_W = 3;
    parameter int unsigned CFG_T_W = 2;

    typedef enum logic [1:0] {
        S_PAR      = 2'd0,
        S_SER_IDLE = 2'd1,
        S_SER_PASS = 2'd2
    } ld_state_t;

    // Field order equals serial frame order: first bit shifted lands on top.
    typedef struct packed {
        logic [CFG_T_W-1:0] tsel;
        logic [CFG_N_W-1:0] nb;
        logic [CFG_N_W-1:0] na;
        logic [CFG_M_W-1:0] m;
    } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nxt,
    output logic         sout
);
    always_comb begin
        q_nxt = q;
        if (shift_en) q_nxt = {q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    assign sout = q[W-1];
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import cfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned M_LOCK_MIN  = 25,
    parameter int unsigned M_LOCK_MAX  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_ld_i,
    input  logic               par_ld_n_i,
    input  logic [CFG_M_W-1:0] par_m_i,
    input  logic [CFG_N_W-1:0] par_na_i,
    input  logic [CFG_N_W-1:0] par_nb_i,
    input  logic               fb_div_i,
    input  logic               outa_clk_i,
    output logic [CFG_M_W-1:0] m_o,
    output logic [CFG_N_W-1:0] na_o,
    output logic [CFG_N_W-1:0] nb_o,
    output logic [CFG_T_W-1:0] tsel_o,
    output logic               test_o,
    output logic               m_in_range_o
);
    localparam int unsigned FRAME_W = $bits(cfg_word_t);
    localparam int unsigned CTRL_W  = 4;
    localparam int unsigned PAR_W   = CFG_M_W + 2 * CFG_N_W;
    localparam int unsigned SYNC_W  = CTRL_W + PAR_W;

    // synchronized inputs
    logic [SYNC_W-1:0] sync_q;
    logic              sclk_lvl, sdat_lvl, sld_lvl, pld_lvl;
    logic [PAR_W-1:0]  par_lvl;

    cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk_i, ser_dat_i, ser_ld_i, par_ld_n_i,
                 par_nb_i, par_na_i, par_m_i}),
        .q     (sync_q)
    );

    assign {sclk_lvl, sdat_lvl, sld_lvl, pld_lvl, par_lvl} = sync_q;

    // edge detection on serial clock, serial strobe, parallel strobe
    logic [2:0] rise_v, fall_v;
    logic       sclk_rise, sld_rise, pld_rise;

    cfg_edge #(.W(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({sclk_lvl, sld_lvl, pld_lvl}),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    assign {sclk_rise, sld_rise, pld_rise} = rise_v;

    // frame shift register
    logic [FRAME_W-1:0] sh_q, sh_nxt;
    logic               sh_out;

    cfg_shreg #(.W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise & pld_lvl),
        .din      (sdat_lvl),
        .q        (sh_q),
        .q_nxt    (sh_nxt),
        .sout     (sh_out)
    );

    // state machine
    ld_state_t st_q, st_nxt;
    cfg_word_t cfg_q, cfg_nxt, par_word;
    logic      cfg_copy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_PAR;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_PAR: begin
                if (pld_rise) st_nxt = sld_lvl ? S_SER_PASS : S_SER_IDLE;
            end
            S_SER_IDLE: begin
                if (!pld_lvl)     st_nxt = S_PAR;
                else if (sld_lvl) st_nxt = S_SER_PASS;
            end
            S_SER_PASS: begin
                if (!pld_lvl)      st_nxt = S_PAR;
                else if (!sld_lvl) st_nxt = S_SER_IDLE;
            end
            default: st_nxt = S_PAR;
        endcase
    end

    // setting registers
    assign par_word = '{tsel: cfg_q.tsel,
                        nb:   par_lvl[PAR_W-1 -: CFG_N_W],
                        na:   par_lvl[CFG_M_W +: CFG_N_W],
                        m:    par_lvl[CFG_M_W-1:0]};

    assign cfg_copy = ((st_q == S_SER_IDLE) && (st_nxt == S_SER_PASS)) ||
                      ((st_q == S_SER_PASS) && (st_nxt == S_SER_PASS) && sclk_rise);

    always_comb begin
        cfg_nxt = cfg_q;
        if (!pld_lvl || st_q == S_PAR) cfg_nxt = par_word;
        else if (cfg_copy)             cfg_nxt = cfg_word_t'(sh_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            m_in_range_o <= 1'b0;
        end else begin
            cfg_q        <= cfg_nxt;
            m_in_range_o <= (32'(cfg_nxt.m) >= M_LOCK_MIN) &&
                            (32'(cfg_nxt.m) <= M_LOCK_MAX);
        end
    end

    // outputs
    assign m_o    = cfg_q.m;
    assign na_o   = cfg_q.na;
    assign nb_o   = cfg_q.nb;
    assign tsel_o = cfg_q.tsel;

    always_comb begin
        test_o = 1'b0;
        if (st_q != S_PAR) begin
            unique case (cfg_q.tsel)
                2'b00:   test_o = 1'b0;
                2'b01:   test_o = sh_out;
                2'b10:   test_o = fb_div_i;
                2'b11:   test_o = outa_clk_i;
                default: test_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
    import cfg_pkg::*;
#(
    parameter int unsigned M_LOCK_MIN = 25,
    parameter int unsigned M_LOCK_MAX = 31
) (
    input logic               clk,
    input logic               rst_n,
    input ld_state_t          st,
    input logic [CFG_M_W-1:0] m_o,
    input logic [CFG_N_W-1:0] na_o,
    input logic [CFG_N_W-1:0] nb_o,
    input logic [CFG_T_W-1:0] tsel_o,
    input logic               test_o,
    input logic               m_in_range_o,
    input logic               fb_div_i,
    input logic               outa_clk_i
);
    // R6: settings stay frozen while the machine remains in serial idle
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SER_IDLE && $past(st) == S_SER_IDLE) |->
            $stable({tsel_o, nb_o, na_o, m_o}));

    // R9: lock-range flag matches the current M value
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_in_range_o == ((32'(m_o) >= M_LOCK_MIN) && (32'(m_o) <= M_LOCK_MAX)));

    // R8: test pin low in parallel mode
    p_test_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAR) |-> !test_o);

    // R7: selector 00 gives a constant low
    p_mux_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_PAR && tsel_o == 2'b00) |-> !test_o);

    // R7: selector 10 routes the feedback divider
    p_mux_fb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_PAR && tsel_o == 2'b10) |-> (test_o == fb_div_i));

    // R7: selector 11 routes the output A clock
    p_mux_oa_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_PAR && tsel_o == 2'b11) |-> (test_o == outa_clk_i));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
    .M_LOCK_MIN (M_LOCK_MIN),
    .M_LOCK_MAX (M_LOCK_MAX)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st_q),
    .m_o          (m_o),
    .na_o         (na_o),
    .nb_o         (nb_o),
    .tsel_o       (tsel_o),
    .test_o       (test_o),
    .m_in_range_o (m_in_range_o),
    .fb_div_i     (fb_div_i),
    .outa_clk_i   (outa_clk_i)
);

// File: tb/synth_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld_n = 1'b0;
    logic [5:0] par_m = 6'd27;
    logic [2:0] par_na = 3'd3, par_nb = 3'd4;
    logic       fb_div = 1'b0, outa_clk = 1'b0;
    logic [5:0] m_o;
    logic [2:0] na_o, nb_o;
    logic [1:0] tsel_o;
    logic       test_o, m_in_range_o;

    int checks = 0;
    int errors = 0;
    logic [13:0] hist = '0;   // bench model of the serial shift register

    // frames {T1,T0,NB,NA,M}
    localparam logic [13:0] VEC [6] = '{
        {2'b01, 3'd5, 3'd2, 6'd25},
        {2'b10, 3'd0, 3'd7, 6'd31},
        {2'b11, 3'd3, 3'd1, 6'd24},
        {2'b00, 3'd6, 3'd4, 6'd32},
        {2'b01, 3'd1, 3'd3, 6'd0},
        {2'b10, 3'd7, 3'd0, 6'd63}
    };

    always #2 clk = ~clk;

    synth_cfg_loader dut_i (
        .clk (clk), .rst_n (rst_n),
        .ser_clk_i (ser_clk), .ser_dat_i (ser_dat), .ser_ld_i (ser_ld),
        .par_ld_n_i (par_ld_n), .par_m_i (par_m), .par_na_i (par_na),
        .par_nb_i (par_nb), .fb_div_i (fb_div), .outa_clk_i (outa_clk),
        .m_o (m_o), .na_o (na_o), .nb_o (nb_o), .tsel_o (tsel_o),
        .test_o (test_o), .m_in_range_o (m_in_range_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] word();
        return {tsel_o, nb_o, na_o, m_o};
    endfunction

    function automatic int in_rng(input logic [5:0] m);
        return (m >= 6'd25 && m <= 6'd31) ? 1 : 0;
    endfunction

    task automatic ser_bit(input logic b);
        ser_dat = b;
        wait_cyc(5);
        ser_clk = 1'b1;
        if (par_ld_n) hist = {hist[12:0], b};
        wait_cyc(5);
        ser_clk = 1'b0;
        wait_cyc(5);
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    task automatic check_mux(input logic [1:0] t);
        logic e;
        fb_div = 1'b1; outa_clk = 1'b0; wait_cyc(2);
        e = (t == 2'b00) ? 1'b0 : (t == 2'b01) ? hist[13] : (t == 2'b10) ? 1'b1 : 1'b0;
        chk("R7 mux a", int'(test_o), int'(e));
        fb_div = 1'b0; outa_clk = 1'b1; wait_cyc(2);
        e = (t == 2'b00) ? 1'b0 : (t == 2'b01) ? hist[13] : (t == 2'b10) ? 1'b0 : 1'b1;
        chk("R7 mux b", int'(test_o), int'(e));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [13:0] prev;
        // R10: reset state
        fb_div = 1'b1;
        wait_cyc(3);
        chk("R10 m", int'(m_o), 0);
        chk("R10 tsel", int'(tsel_o), 0);
        chk("R10 test", int'(test_o), 0);
        chk("R10 range", int'(m_in_range_o), 0);
        rst_n = 1'b1;
        wait_cyc(6);
        // R1, R9, R8: parallel tracking
        chk("R1 m", int'(m_o), 27);
        chk("R1 na", int'(na_o), 3);
        chk("R1 nb", int'(nb_o), 4);
        chk("R9 in", int'(m_in_range_o), 1);
        chk("R8 test low", int'(test_o), 0);
        par_m = 6'd20; wait_cyc(6);
        chk("R1 m follow", int'(m_o), 20);
        chk("R9 out", int'(m_in_range_o), 0);
        // R2: capture on rising strobe
        par_ld_n = 1'b1; wait_cyc(6);
        par_m = 6'd10; par_na = 3'd6; wait_cyc(6);
        chk("R2 m held", int'(m_o), 20);
        chk("R2 na held", int'(na_o), 3);
        prev = {2'b00, 3'd4, 3'd3, 6'd20};
        // vector table: R3, R4, R6, R7, R9
        for (int k = 0; k < 6; k++) begin
            send_frame(VEC[k]);
            chk("R4 no load before strobe", int'(word()), int'(prev));
            ser_ld = 1'b1; wait_cyc(6);
            ser_ld = 1'b0; wait_cyc(6);
            chk("R3 frame", int'(word()), int'(VEC[k]));
            chk("R9 range", int'(m_in_range_o), in_rng(VEC[k][5:0]));
            check_mux(VEC[k][13:12]);
            ser_bit(1'b1);
            chk("R6 frozen", int'(word()), int'(VEC[k]));
            check_mux(VEC[k][13:12]);
            prev = VEC[k];
        end
        // R5: pass-through while serial strobe high
        ser_ld = 1'b1; wait_cyc(6);
        chk("R5 copy", int'(word()), int'(hist));
        ser_bit(1'b0);
        chk("R5 step", int'(word()), int'(hist));
        send_frame({2'b10, 3'd2, 3'd5, 6'd28});
        chk("R5 frame", int'(word()), int'({2'b10, 3'd2, 3'd5, 6'd28}));
        chk("R9 pass", int'(m_in_range_o), 1);
        ser_ld = 1'b0; wait_cyc(6);
        send_frame({2'b01, 3'd1, 3'd1, 6'd1});
        chk("R6 after fall", int'(word()), int'({2'b10, 3'd2, 3'd5, 6'd28}));
        // R11: parallel strobe low overrides serial
        par_m = 6'd29; par_na = 3'd1; par_nb = 3'd2;
        ser_ld = 1'b1; wait_cyc(6);
        par_ld_n = 1'b0; fb_div = 1'b1; wait_cyc(6);
        chk("R11 m", int'(m_o), 29);
        chk("R8 par test", int'(test_o), 0);
        ser_bit(1'b0);
        ser_bit(1'b1);
        chk("R11 m after sclk", int'(m_o), 29);
        chk("R11 nb after sclk", int'(nb_o), 2);
        ser_ld = 1'b0; wait_cyc(6);
        chk("R11 m after sld", int'(m_o), 29);
        // R10: reset in operation
        rst_n = 1'b0; wait_cyc(2);
        chk("R10 m again", int'(m_o), 0);
        chk("R10 range again", int'(m_in_range_o), 0);
        chk("R10 tsel again", int'(tsel_o), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule